// File: doc/BRIEF.md
# Flash Page Program Buffer Unit

This block sits in front of a byte-wide flash array that is split into several equal array blocks. Software streams the bytes to be programmed into a staging buffer made of `NBUF` buffers of `BUF_BYTES` bytes each. The first byte accepted after the buffer was last emptied fixes the starting offset inside a block. Every later byte lands at the next sequential offset. A block-select mask names which array blocks take part. One program command then writes the same offsets in all of those blocks during a single pass.

A program pass walks the staged bytes one per clock. Each byte is ANDed into the same offset of every selected block, so array bits can only go from 1 to 0. When the pass ends, a one-cycle done pulse is raised and the staging buffer is emptied. Each block keeps a record of the pages it has programmed since its last erase. If a program pass touches one of those pages again, that block's over-program flag is set, and it stays set until the block is erased. An erase command returns every byte of the selected blocks to 0xFF and clears their page record and flag. A combinational read port exposes the array contents.

The staging input is a valid/ready stream. A byte moves only on a clock edge where `wr_valid` and `wr_ready` are both high. The source must hold the byte and its address stable while `wr_ready` is low. Back-pressure is applied while a pass runs, in the cycle in which `pgm_start` is raised, and when the buffer is full.

Top module: `fpb_unit`

## Requirements
- R1: After reset, `wr_ready` is 1, `busy`, `pgm_done` and every `ovp_flag` bit are 0, and every array byte reads 0xFF.
- R2: A byte is accepted only on an edge with `wr_valid` and `wr_ready` both high. `wr_ready` is 0 while `busy` is 1, while `pgm_start` is 1, and while the buffer holds `NBUF*BUF_BYTES` bytes.
- R3: The first byte accepted into an empty buffer is placed at offset `wr_addr`. The n-th later byte goes to that offset plus n, modulo the block size, and its own `wr_addr` is ignored.
- R4: A program pass turns each targeted array byte into its old value AND the staged byte. A bit that reads 0 is never set by programming.
- R5: Array bytes outside the staged offset range, and every byte of unselected blocks, keep their value through a program pass.
- R6: A pass programs every block whose bit is 1 in the select mask. Any combination is allowed, including all blocks or none.
- R7: `pgm_start` is taken when `busy` is 0. `pgm_done` is high for exactly one cycle, starting N clock edges after the accepting edge for N staged bytes (on that same edge when N is 0). `busy` is high from the accepting edge until the cycle after the pulse.
- R8: After the done pulse the buffer is empty, so the next accepted byte captures a new starting offset.
- R9: When a pass is accepted, `ovp_flag[b]` is set for each selected block b in which a page (`PAGE_BYTES`-aligned) touched by the staged bytes was already programmed since b's last erase. Flags change only at such an acceptance or at an erase.
- R10: `erase_start`, taken when `busy` and `pgm_start` are 0, sets every byte of the selected blocks to 0xFF and clears their page record and `ovp_flag` bit. It is ignored while `busy` is 1.
- R11: `sel_we` loads `sel_in` into the select mask only while `busy` is 0. A pass already running keeps the mask it started with.
- R12: `rd_data` shows the array byte at offset `rd_off` of block `rd_blk` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Staging byte is offered |
| wr_ready | output | 1 | Staging byte can be taken this edge |
| wr_addr | input | log2(BLK_PAGES*PAGE_BYTES) | Offset inside a block; used only for the first byte |
| wr_data | input | 8 | Staging byte |
| sel_we | input | 1 | Load the block-select mask |
| sel_in | input | NUM_BLK | New block-select mask |
| pgm_start | input | 1 | Request a program pass |
| erase_start | input | 1 | Request an erase of the selected blocks |
| busy | output | 1 | Program pass in progress |
| pgm_done | output | 1 | One-cycle end-of-pass pulse |
| ovp_flag | output | NUM_BLK | Over-program flag per block |
| rd_blk | input | log2(NUM_BLK) | Read block index |
| rd_off | input | log2(BLK_PAGES*PAGE_BYTES) | Read offset |
| rd_data | output | 8 | Array byte at the read address |

## Verification
The properties assume that `pgm_start` and `erase_start` are plain level requests sampled once per edge. They also assume that a source offering a byte keeps offering it until it is accepted. The flag properties treat an accepted erase as the only event that may clear a flag. The stimulus changes every input half a cycle away from the rising edge, and it raises `wr_valid` only while the buffer has room. Commands issued during a pass are deliberately included, to show that they are ignored.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_APPLY = 2'd1,
    SQ_DONE  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fpb_loader.sv
// Staging buffer: captures the start offset, stores bytes sequentially,
// and marks every page touched by the staged range.
module fpb_loader #(
  parameter int NBUF       = 8,
  parameter int BUF_BYTES  = 64,
  parameter int BLK_BYTES  = 512,
  parameter int PAGE_BYTES = 64
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   accept,
  input  logic [$clog2(BLK_BYTES)-1:0]           wr_addr,
  input  logic [7:0]                             wr_data,
  input  logic                                   clear,
  input  logic [$clog2(NBUF*BUF_BYTES)-1:0]      rd_idx,
  output logic [$clog2(NBUF*BUF_BYTES+1)-1:0]    count,
  output logic                                   full,
  output logic [BLK_BYTES/PAGE_BYTES-1:0]        touched,
  output logic [7:0]                             rd_byte,
  output logic [$clog2(BLK_BYTES)-1:0]           rd_off
);
  localparam int CAP   = NBUF * BUF_BYTES;
  localparam int IDX_W = $clog2(CAP);
  localparam int CNT_W = $clog2(CAP + 1);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int PG_W  = $clog2(PAGE_BYTES);

  logic [7:0]       sbuf_q [CAP];
  logic [OFF_W-1:0] base_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] pos;

  // Array offset of the byte being accepted now
  always_comb begin
    if (cnt_q == '0) pos = wr_addr;
    else             pos = base_q + OFF_W'(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      base_q  <= '0;
      touched <= '0;
    end else if (clear) begin
      cnt_q   <= '0;
      touched <= '0;
    end else if (accept) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) base_q <= wr_addr;
      touched[pos[OFF_W-1:PG_W]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) sbuf_q[cnt_q[IDX_W-1:0]] <= wr_data;
  end

  assign count   = cnt_q;
  assign full    = (cnt_q == CNT_W'(CAP));
  assign rd_byte = sbuf_q[rd_idx];
  assign rd_off  = base_q + OFF_W'(rd_idx);
endmodule

// File: rtl/fpb_sequencer.sv
// Program pass control: one staged byte per clock, then a done cycle.
module fpb_sequencer
  import fpb_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pgm_start,
  input  logic [CNT_W-1:0] count,
  output logic             go,
  output logic             busy,
  output logic             apply_en,
  output logic [IDX_W-1:0] apply_idx,
  output logic             done
);
  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] idx_q;

  always_comb begin
    st_d     = st_q;
    apply_en = 1'b0;
    done     = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (pgm_start) st_d = (count == '0) ? SQ_DONE : SQ_APPLY;
      end
      SQ_APPLY: begin
        apply_en = 1'b1;
        if (idx_q == count - 1'b1) st_d = SQ_DONE;
      end
      SQ_DONE: begin
        done = 1'b1;
        st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == SQ_APPLY) idx_q <= idx_q + 1'b1;
      else                  idx_q <= '0;
    end
  end

  assign go        = (st_q == SQ_IDLE) && pgm_start;
  assign busy      = (st_q != SQ_IDLE);
  assign apply_idx = idx_q[IDX_W-1:0];
endmodule

// File: rtl/fpb_array.sv
// Array blocks with AND-only programming, erase, page history and flags.
module fpb_array #(
  parameter int NUM_BLK    = 4,
  parameter int BLK_BYTES  = 512,
  parameter int PAGE_BYTES = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_BLK-1:0]                 blk_sel,
  input  logic                               erase_go,
  input  logic                               pgm_go,
  input  logic [BLK_BYTES/PAGE_BYTES-1:0]    touched,
  input  logic                               apply_en,
  input  logic [$clog2(BLK_BYTES)-1:0]       apply_off,
  input  logic [7:0]                         apply_byte,
  input  logic [$clog2(NUM_BLK)-1:0]         rd_blk,
  input  logic [$clog2(BLK_BYTES)-1:0]       rd_off,
  output logic [7:0]                         rd_data,
  output logic [NUM_BLK-1:0]                 ovp
);
  localparam int NPAGE = BLK_BYTES / PAGE_BYTES;

  logic [7:0] rd_vec [NUM_BLK];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    logic [7:0]       mem_q [BLK_BYTES];
    logic [NPAGE-1:0] pgmd_q;
    logic             ovp_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < BLK_BYTES; i++) mem_q[i] <= 8'hFF;
        pgmd_q <= '0;
        ovp_q  <= 1'b0;
      end else if (erase_go && blk_sel[b]) begin
        for (int i = 0; i < BLK_BYTES; i++) mem_q[i] <= 8'hFF;
        pgmd_q <= '0;
        ovp_q  <= 1'b0;
      end else begin
        if (pgm_go && blk_sel[b]) begin
          if (|(pgmd_q & touched)) ovp_q <= 1'b1;
          pgmd_q <= pgmd_q | touched;
        end
        if (apply_en && blk_sel[b])
          mem_q[apply_off] <= mem_q[apply_off] & apply_byte;
      end
    end

    assign rd_vec[b] = mem_q[rd_off];
    assign ovp[b]    = ovp_q;
  end

  assign rd_data = rd_vec[rd_blk];
endmodule

// File: rtl/fpb_unit.sv
module fpb_unit #(
  parameter int NUM_BLK    = 4,
  parameter int NBUF       = 8,
  parameter int BUF_BYTES  = 64,
  parameter int BLK_PAGES  = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     wr_valid,
  output logic                                     wr_ready,
  input  logic [$clog2(BLK_PAGES*PAGE_BYTES)-1:0]  wr_addr,
  input  logic [7:0]                               wr_data,
  input  logic                                     sel_we,
  input  logic [NUM_BLK-1:0]                       sel_in,
  input  logic                                     pgm_start,
  input  logic                                     erase_start,
  output logic                                     busy,
  output logic                                     pgm_done,
  output logic [NUM_BLK-1:0]                       ovp_flag,
  input  logic [$clog2(NUM_BLK)-1:0]               rd_blk,
  input  logic [$clog2(BLK_PAGES*PAGE_BYTES)-1:0]  rd_off,
  output logic [7:0]                               rd_data
);
  localparam int BLK_BYTES = BLK_PAGES * PAGE_BYTES;
  localparam int CAP       = NBUF * BUF_BYTES;
  localparam int IDX_W     = $clog2(CAP);
  localparam int CNT_W     = $clog2(CAP + 1);
  localparam int OFF_W     = $clog2(BLK_BYTES);

  logic [NUM_BLK-1:0]   sel_q;
  logic                 accept, full, clear, go, apply_en, erase_go;
  logic [CNT_W-1:0]     count;
  logic [BLK_PAGES-1:0] touched;
  logic [IDX_W-1:0]     apply_idx;
  logic [7:0]           apply_byte;
  logic [OFF_W-1:0]     apply_off;

  assign wr_ready = !busy && !pgm_start && !full;
  assign accept   = wr_valid && wr_ready;
  assign erase_go = erase_start && !busy && !pgm_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sel_q <= '0;
    else if (sel_we && !busy) sel_q <= sel_in;
  end

  fpb_loader #(
    .NBUF(NBUF), .BUF_BYTES(BUF_BYTES),
    .BLK_BYTES(BLK_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_loader (
    .clk(clk), .rst_n(rst_n), .accept(accept), .wr_addr(wr_addr),
    .wr_data(wr_data), .clear(clear), .rd_idx(apply_idx), .count(count),
    .full(full), .touched(touched), .rd_byte(apply_byte), .rd_off(apply_off)
  );

  fpb_sequencer #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .pgm_start(pgm_start), .count(count),
    .go(go), .busy(busy), .apply_en(apply_en), .apply_idx(apply_idx),
    .done(pgm_done)
  );

  assign clear = pgm_done;

  fpb_array #(
    .NUM_BLK(NUM_BLK), .BLK_BYTES(BLK_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .blk_sel(sel_q), .erase_go(erase_go),
    .pgm_go(go), .touched(touched), .apply_en(apply_en),
    .apply_off(apply_off), .apply_byte(apply_byte), .rd_blk(rd_blk),
    .rd_off(rd_off), .rd_data(rd_data), .ovp(ovp_flag)
  );
endmodule

// File: rtl/fpb_unit_chk.sv
module fpb_unit_chk #(
  parameter int NUM_BLK = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_ready,
  input logic               pgm_start,
  input logic               erase_start,
  input logic               busy,
  input logic               pgm_done,
  input logic [NUM_BLK-1:0] ovp_flag
);
  AST_BUSY_HOLDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready); // R2
  AST_START_HOLDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> !wr_ready); // R2
  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_start && !busy) |=> busy); // R7
  AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_done |-> busy); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_done |=> (!pgm_done && !busy)); // R7
  AST_OVP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_start || busy || pgm_start) |=>
      ((ovp_flag & $past(ovp_flag)) == $past(ovp_flag))); // R9
  AST_OVP_RISE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_start && !busy) |=> ((ovp_flag & ~$past(ovp_flag)) == '0)); // R9
endmodule

bind fpb_unit fpb_unit_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .pgm_start(pgm_start),
  .erase_start(erase_start), .busy(busy), .pgm_done(pgm_done),
  .ovp_flag(ovp_flag)
);

// File: tb/fpb_unit_bench.sv
`timescale 1ns/1ps
module fpb_unit_bench;
  localparam int NB  = 4;
  localparam int BB  = 512;
  localparam int CAP = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_ready;
  logic [8:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sel_we = 1'b0;
  logic [3:0] sel_in = '0;
  logic       pgm_start = 1'b0, erase_start = 1'b0;
  logic       busy, pgm_done;
  logic [3:0] ovp_flag;
  logic [1:0] rd_blk = '0;
  logic [8:0] rd_off = '0;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  fpb_unit u_fpb_unit (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .sel_we(sel_we), .sel_in(sel_in),
    .pgm_start(pgm_start), .erase_start(erase_start), .busy(busy),
    .pgm_done(pgm_done), .ovp_flag(ovp_flag), .rd_blk(rd_blk),
    .rd_off(rd_off), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [NB][BB];
  logic [3:0] cur_sel = '0;

  // Fields: sel(4) off(9) len(10) seed(8) expected ovp(4)
  localparam logic [34:0] OPS [6] = '{
    {4'b0001, 9'd0,   10'd64,  8'hA5, 4'b0000},
    {4'b0110, 9'd100, 10'd70,  8'h3C, 4'b0000},
    {4'b1111, 9'd500, 10'd20,  8'h5A, 4'b0001},
    {4'b0100, 9'd128, 10'd1,   8'h00, 4'b0101},
    {4'b1000, 9'd256, 10'd512, 8'h07, 4'b1101},
    {4'b0000, 9'd10,  10'd5,   8'h11, 4'b1101}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return seed ^ 8'(k * 29) ^ 8'(k >> 3);
  endfunction

  task automatic cmp_array(input string tag);
    int bad = 0, fa = 0, fe = 0;
    for (int b = 0; b < NB; b++)
      for (int o = 0; o < BB; o++) begin
        rd_blk = 2'(b); rd_off = 9'(o);
        #0.1;
        if (rd_data !== mdl[b][o]) begin
          if (bad == 0) begin fa = int'(rd_data); fe = int'(mdl[b][o]); end
          bad++;
        end
      end
    check(bad == 0, tag, fa, fe);
  endtask

  task automatic push(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic set_sel(input logic [3:0] m);
    @(negedge clk); sel_we = 1'b1; sel_in = m;
    @(posedge clk); #1 sel_we = 1'b0;
    cur_sel = m;
  endtask

  task automatic erase(input logic [3:0] m);
    set_sel(m);
    @(negedge clk); erase_start = 1'b1;
    @(posedge clk); #1 erase_start = 1'b0;
    for (int b = 0; b < NB; b++)
      if (m[b]) for (int o = 0; o < BB; o++) mdl[b][o] = 8'hFF;
  endtask

  // Stage len bytes, run a pass, check its timing; poke = issue commands mid-pass
  task automatic run_pass(input logic [8:0] off, input int len,
                          input logic [7:0] seed, input bit poke);
    int cnt;
    for (int k = 0; k < len; k++)
      push((k == 0) ? off : (off ^ 9'(k * 7 + 1)), pat(seed, k));
    if (len == CAP) begin
      @(negedge clk);
      check(wr_ready == 1'b0, "R2 full buffer back-pressure", wr_ready, 0);
    end
    @(negedge clk); pgm_start = 1'b1;
    @(posedge clk); #1 pgm_start = 1'b0;
    cnt = 0;
    @(negedge clk);
    check(busy == 1'b1, "R7 busy after start", busy, 1);
    if (poke) begin
      check(wr_ready == 1'b0, "R2 no ready while busy", wr_ready, 0);
      sel_we = 1'b1; sel_in = 4'b1111; erase_start = 1'b1;
      @(posedge clk); #1 sel_we = 1'b0; erase_start = 1'b0;
      @(negedge clk); cnt++;
    end
    while (!pgm_done && cnt < 5000) begin @(negedge clk); cnt++; end
    check(cnt == len, "R7 done pulse timing", cnt, len);
    for (int k = 0; k < len; k++)
      for (int b = 0; b < NB; b++)
        if (cur_sel[b]) mdl[b][9'(int'(off) + k)] &= pat(seed, k);
    @(negedge clk);
    check(!busy && !pgm_done && wr_ready, "R8 idle and empty after pass",
          {busy, pgm_done, wr_ready}, 1);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) for (int o = 0; o < BB; o++) mdl[b][o] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(wr_ready && !busy && !pgm_done, "R1 reset outputs",
          {wr_ready, busy, pgm_done}, 4);
    check(ovp_flag == 4'b0, "R1 reset flags", ovp_flag, 0);
    cmp_array("R1 erased array after reset");

    // Table walk: R3 R4 R5 R6 R9 R12
    for (int i = 0; i < 6; i++) begin
      logic [34:0] e;
      e = OPS[i];
      set_sel(e[34:31]);
      run_pass(e[30:22], int'(e[21:12]), e[11:4], 1'b0);
      check(ovp_flag == e[3:0], "R9 over-program flags", ovp_flag, e[3:0]);
      cmp_array("R4 R5 R6 R3 R12 array contents");
    end

    // R10 erase clears selected blocks and their flags
    erase(4'b0101);
    @(negedge clk);
    check(ovp_flag == 4'b1000, "R10 erase clears flags", ovp_flag, 4'b1000);
    cmp_array("R10 erased blocks read 0xFF");

    // R7 empty pass: done on the accepting edge
    run_pass(9'd0, 0, 8'h00, 1'b0);

    // R11 R10: mask write and erase during a pass are ignored
    set_sel(4'b0010);
    run_pass(9'd300, 40, 8'hC3, 1'b1);
    cmp_array("R10 R11 commands ignored while busy");
    check(ovp_flag == 4'b1000, "R9 fresh pages no flag", ovp_flag, 4'b1000);
    cur_sel = 4'b0010;
    run_pass(9'd0, 1, 8'h00, 1'b0);
    check(ovp_flag == 4'b1010, "R11 mask kept, R9 repeat page", ovp_flag, 4'b1010);
    cmp_array("R11 only old mask block changed");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule